// File: doc/BRIEF.md
# Triple-Oversampled Frame-Synchronised UART Receiver

This block receives asynchronous 8-N-1 characters with a word-based shifter that takes three samples per bit time. The samples come from a free-running tick at a fixed number of system clocks per sample. The line input first passes through a two-flop synchronizer. While the receiver is armed, the first sample tick that sees the line low counts as the frame start, and that sample is word sample 0. A capture then takes 29 samples. The middle sample of each data bit makes up the byte, least significant bit first.

A capture holds only two of the three stop-bit samples. The receiver is armed again on the very next tick, so a transmitter whose stop bit runs a third of a bit short still has its next start bit caught at that start bit's first sample. Without this, the error would add up from one character to the next. Each decoded byte goes into a small first-word-fall-through queue. The queue reports when it holds data and raises a sticky overflow flag when a byte arrives while it is full. Parity and framing errors are not checked.

Top module: `tri_sample_uart_rx`

## Requirements
- R1: After synchronous reset, `rx_not_empty` and `rx_overflow` are both 0 and no byte can be read.
- R2: One bit lasts 3 sample ticks, and one tick occurs every `CLK_PER_SAMPLE` clocks. While armed, a tick that sees the synchronized line at 0 starts a word, and that tick is sample 0. The word then captures samples 1 to 28 on the following 28 ticks.
- R3: Counting samples 0..28 in arrival order, data bit k (k = 0..7) is taken from sample 4+3k. Bit 0 is the least significant bit of the byte.
- R4: The receiver is armed again on the tick right after sample 28. Characters sent back to back, each with a stop bit only 2 samples long, are all received intact.
- R5: A line held high creates no byte.
- R6: The queue holds `FIFO_DEPTH` (8) bytes in arrival order. `rd_data` shows the oldest byte whenever `rx_not_empty` is 1, and a one-cycle `rd_en` removes that byte.
- R7: A byte that completes while the queue is full, with no read in the same cycle, is discarded and sets `rx_overflow`. The bytes already stored are not changed.
- R8: `rx_overflow` stays at 1 until `ovf_clr` is driven to 1 for a cycle, which returns it to 0.
- R9: `rd_en` while the queue is empty has no effect. Later bytes are still stored and read in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial line, idle high |
| rd_en | input | 1 | Removes the oldest byte from the queue |
| ovf_clr | input | 1 | Write-1 clear of the overflow flag |
| rd_data | output | 8 | Oldest byte in the queue |
| rx_not_empty | output | 1 | Queue holds at least one byte |
| rx_overflow | output | 1 | Sticky flag: a byte was lost to a full queue |

## Verification
On every cycle, the embedded properties check these points: two sample ticks are never adjacent, a decoded byte appears only on a tick and with the framer armed again, the queue occupancy never exceeds its depth, a full-queue write raises the overflow flag, the flag holds until it is cleared, and a read from an empty queue leaves the queue empty. The scenarios are the only way to show the actual byte values: the choice of the middle sample, bit order, and re-synchronisation across a run of characters with short stop bits. They also show that exactly the ninth byte of a burst is the one dropped, and that the line at idle creates nothing.

// File: rtl/u3x_pkg.sv
package u3x_pkg;

    localparam int SAMPLES_PER_BIT = 3;
    localparam int DATA_BITS       = 8;
    localparam int STOP_SAMPLES    = SAMPLES_PER_BIT - 1;
    localparam int WORD_SAMPLES    = (1 + DATA_BITS) * SAMPLES_PER_BIT + STOP_SAMPLES;
    localparam int LAST_SAMPLE     = WORD_SAMPLES - 1;
    localparam int FIRST_DATA      = SAMPLES_PER_BIT + SAMPLES_PER_BIT / 2;
    localparam int LAST_DATA       = FIRST_DATA + SAMPLES_PER_BIT * (DATA_BITS - 1);
    localparam int IDX_W           = $clog2(WORD_SAMPLES);
    localparam int BIT_W           = $clog2(DATA_BITS);

    typedef logic [DATA_BITS-1:0] byte_t;
    typedef logic [IDX_W-1:0]     samp_idx_t;

    typedef enum logic {
        FRM_ARMED,
        FRM_CAPTURE
    } frm_state_e;

    typedef struct packed {
        logic  valid;
        byte_t data;
    } rx_byte_t;

    function automatic logic is_data_slot(samp_idx_t i);
        int ii;
        ii = int'(i);
        return (ii >= FIRST_DATA) && (ii <= LAST_DATA) &&
               (((ii - FIRST_DATA) % SAMPLES_PER_BIT) == 0);
    endfunction

    function automatic logic [BIT_W-1:0] data_bit_of(samp_idx_t i);
        int k;
        k = (int'(i) - FIRST_DATA) / SAMPLES_PER_BIT;
        return BIT_W'(k);
    endfunction

endpackage

// File: rtl/u3x_tick.sv
module u3x_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                end else if (cnt == CW'(DIV - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = (cnt == CW'(DIV - 1));

            // R2: ticks are spaced by the divider, never back to back
            p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/u3x_framer.sv
module u3x_framer
    import u3x_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     line_i,
    output rx_byte_t byte_o
);
    logic       sync_a, sync_b;
    frm_state_e state;
    samp_idx_t  idx;
    byte_t      shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a <= 1'b1;
            sync_b <= 1'b1;
        end else begin
            sync_a <= line_i;
            sync_b <= sync_a;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= FRM_ARMED;
            idx    <= '0;
            shreg  <= '0;
            byte_o <= '0;
        end else begin
            byte_o.valid <= 1'b0;
            if (tick) begin
                case (state)
                    FRM_ARMED: begin
                        if (!sync_b) begin
                            state <= FRM_CAPTURE;
                            idx   <= samp_idx_t'(1);
                        end
                    end
                    default: begin
                        if (is_data_slot(idx)) begin
                            shreg[data_bit_of(idx)] <= sync_b;
                        end
                        if (idx == samp_idx_t'(LAST_SAMPLE)) begin
                            state        <= FRM_ARMED;
                            byte_o.valid <= 1'b1;
                            byte_o.data  <= shreg;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // R2: a finished word is reported only as the result of a sample tick
    p_byte_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        byte_o.valid |-> $past(tick));

    // R4: when a byte is reported the framer is already re-armed
    p_rearm_r4: assert property (@(posedge clk) disable iff (rst)
        byte_o.valid |-> (state == FRM_ARMED));

    // R2: the sample index never runs past the word length
    p_idx_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (state == FRM_CAPTURE) |-> (int'(idx) <= LAST_SAMPLE));
endmodule

// File: rtl/u3x_fifo.sv
module u3x_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    input  logic         ovf_clr,
    output logic [W-1:0] rdata,
    output logic         not_empty,
    output logic         ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          full, do_rd, do_wr, lost;

    assign full      = (count == CW'(DEPTH));
    assign not_empty = (count != '0);
    assign do_rd     = rd && not_empty;
    assign do_wr     = wr && (!full || do_rd);
    assign lost      = wr && full && !do_rd;
    assign rdata     = mem[rptr];

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_wr) wptr <= bump(wptr);
            if (do_rd) rptr <= bump(rptr);
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (lost) begin
                ovf <= 1'b1;
            end else if (ovf_clr) begin
                ovf <= 1'b0;
            end
        end
    end

    // R6: occupancy never exceeds the depth
    p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= DEPTH);

    // R7: a write into a full queue without a read raises the flag
    p_full_write_r7: assert property (@(posedge clk) disable iff (rst)
        (full && wr && !rd) |=> ovf);

    // R8: the flag is sticky until cleared
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);

    // R9: reading an empty queue leaves it empty
    p_empty_read_r9: assert property (@(posedge clk) disable iff (rst)
        (!not_empty && rd && !wr) |=> !not_empty);
endmodule

// File: rtl/tri_sample_uart_rx.sv
module tri_sample_uart_rx
    import u3x_pkg::*;
#(
    parameter int CLK_PER_SAMPLE = 4,
    parameter int FIFO_DEPTH     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_line,
    input  logic                 rd_en,
    input  logic                 ovf_clr,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 rx_not_empty,
    output logic                 rx_overflow
);
    logic     tick;
    rx_byte_t word;

    u3x_tick #(.DIV(CLK_PER_SAMPLE)) i_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    u3x_framer i_framer (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .line_i (rx_line),
        .byte_o (word)
    );

    u3x_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_BITS)) i_fifo (
        .clk       (clk),
        .rst       (rst),
        .wr        (word.valid),
        .wdata     (word.data),
        .rd        (rd_en),
        .ovf_clr   (ovf_clr),
        .rdata     (rd_data),
        .not_empty (rx_not_empty),
        .ovf       (rx_overflow)
    );
endmodule

// File: tb/test_tri_sample_uart_rx.sv
module test_tri_sample_uart_rx;
    localparam int CPS = 4;
    localparam int BIT_CLKS = 3 * CPS;
    localparam int SHORT_STOP = 2 * CPS;

    // {short_stop, byte}
    localparam logic [8:0] VEC [8] = '{
        9'h1_55, 9'h1_A3, 9'h1_00, 9'h0_FF,
        9'h1_01, 9'h1_80, 9'h0_3C, 9'h1_C5
    };

    logic clk = 1'b0;
    logic rst, rx_line, rd_en, ovf_clr;
    logic [7:0] rd_data;
    logic rx_not_empty, rx_overflow;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tri_sample_uart_rx #(.CLK_PER_SAMPLE(CPS), .FIFO_DEPTH(8)) i_tri_sample_uart_rx (
        .clk(clk), .rst(rst), .rx_line(rx_line), .rd_en(rd_en), .ovf_clr(ovf_clr),
        .rd_data(rd_data), .rx_not_empty(rx_not_empty), .rx_overflow(rx_overflow)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rx_line = v;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [7:0] b, input logic short_stop);
        hold(1'b0, BIT_CLKS);
        for (int i = 0; i < 8; i++) hold(b[i], BIT_CLKS);
        hold(1'b1, short_stop ? SHORT_STOP : BIT_CLKS);
    endtask

    task automatic pop_check(input string req, input logic [7:0] exp);
        @(negedge clk);
        check(req, int'(rx_not_empty), 1);
        check(req, int'(rd_data), int'(exp));
        @(posedge clk); #1 rd_en = 1'b1;
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; rx_line = 1'b1; rd_en = 1'b0; ovf_clr = 1'b0;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 not_empty", int'(rx_not_empty), 0);
        check("R1 overflow", int'(rx_overflow), 0);

        // R5: idle line creates no byte
        hold(1'b1, 300);
        @(negedge clk);
        check("R5 idle", int'(rx_not_empty), 0);

        // R2 R3 R4 R6: table of characters, mostly with shortened stop bits
        @(posedge clk); #1;
        foreach (VEC[i]) send(VEC[i][7:0], VEC[i][8]);
        hold(1'b1, 4 * BIT_CLKS);
        @(negedge clk);
        check("R6 no overflow at exactly full", int'(rx_overflow), 0);
        foreach (VEC[i]) pop_check("R3 R4 R6 byte", VEC[i][7:0]);
        @(negedge clk);
        check("R6 empty after drain", int'(rx_not_empty), 0);

        // R9: read while empty, then the queue still works
        @(posedge clk); #1 rd_en = 1'b1;
        repeat (3) @(posedge clk);
        #1 rd_en = 1'b0;
        @(negedge clk);
        check("R9 empty read", int'(rx_not_empty), 0);
        @(posedge clk); #1;
        send(8'h5A, 1'b1);
        send(8'h96, 1'b1);
        hold(1'b1, 4 * BIT_CLKS);
        pop_check("R9 after empty read", 8'h5A);
        pop_check("R9 after empty read", 8'h96);
        @(negedge clk);
        check("R9 empty again", int'(rx_not_empty), 0);

        // R7: nine bytes into eight slots
        @(posedge clk); #1;
        for (int i = 0; i < 9; i++) send(8'(8'h10 + i), 1'b0);
        hold(1'b1, 4 * BIT_CLKS);
        @(negedge clk);
        check("R7 overflow set", int'(rx_overflow), 1);
        for (int i = 0; i < 8; i++) pop_check("R7 stored bytes kept", 8'(8'h10 + i));
        @(negedge clk);
        check("R7 ninth dropped", int'(rx_not_empty), 0);

        // R8: sticky then write-1 clear
        @(posedge clk); #1;
        repeat (50) @(posedge clk);
        @(negedge clk);
        check("R8 sticky", int'(rx_overflow), 1);
        @(posedge clk); #1 ovf_clr = 1'b1;
        @(posedge clk); #1 ovf_clr = 1'b0;
        @(negedge clk);
        check("R8 cleared", int'(rx_overflow), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule